// File: doc/BRIEF.md
# Multi-Mode 16-bit Timer Channel

This block is one 16-bit down-counting timer channel. An 8-bit prescaler sets how often it counts. A 3-bit mode input selects one of five behaviours, and all five share one counter:

- **One-shot**: counts down once from the load value and stops.
- **Periodic**: reloads automatically at each timeout and keeps running.
- **Edge-count**: each qualifying edge on an external input decrements the counter.
- **Edge-time**: the running count is copied into a capture register on a qualifying edge.
- **Simple PWM**: the output level comes from comparing the counter with a match value.

The external input arrives already synchronized. The block compares its current sample with the previous one to find edges.

Software-facing settings arrive as plain inputs: load value with a write strobe, match value, mode, edge selection, prescale, output inversion and stall enable. The outputs are:

- two sticky event flags, for timeout and for capture/match;
- the PWM pin;
- the live counter;
- the capture register.

A debug halt input can freeze the count in the two plain timer modes when stalling is enabled.

Top module: `mtimer16`

## Requirements
- R1: After reset the counter, the capture register and both flags read zero.
- R2: In the tick-driven modes (mode 0 one-shot, 1 periodic, 3 edge-time, 4 PWM), the counter steps down by one every prescale+1 clocks. The first step lands prescale+1 clocks after enable rises.
- R3: In one-shot mode (mode 0), the step that takes the counter from 1 to 0 sets the timeout flag. The counter then holds at zero while enabled. Dropping enable afterwards reloads the counter from the load register.
- R4: In periodic mode (mode 1), a step from a count of 1 or less reloads the load register value instead of reaching zero, and sets the timeout flag.
- R5: In edge-count mode (mode 2), each qualifying edge decrements the counter. When the decremented value equals the match value, the counter reloads the load value and the event flag sets.
- R6: Edge selection encodings: 0 is rising, 1 is falling, 2 is both, 3 is none. An edge is a difference between the current input sample and the previous one.
- R7: In edge-time mode (mode 3), a qualifying edge copies the counter value held before that clock's update into the capture register and sets the event flag. The counter wraps by reloading, as in periodic mode, without touching the timeout flag.
- R8: In PWM mode (mode 4), the pin equals (counter >= match) XOR invert. The counter reloads as in periodic mode and never sets the timeout flag.
- R9: With stall enable and debug halt both high, the counter and the prescaler hold in modes 0 and 1 only. Other modes keep counting, and halt without stall enable has no effect.
- R10: A load strobe always updates the load register. While the channel is disabled it also writes the counter. While the channel is enabled the counter is left alone, and the new value is used at the next reload.
- R11: Each flag stays set until its clear pulse. A set and a clear in the same clock leave the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Channel run enable |
| mode | input | 3 | 0 one-shot, 1 periodic, 2 edge-count, 3 edge-time, 4 PWM |
| prescale | input | 8 | Prescaler terminal value (divide by value+1) |
| load_val | input | 16 | Load register write data |
| load_we | input | 1 | Load register write strobe |
| match_val | input | 16 | Match value for edge-count and PWM |
| edge_sel | input | 2 | Qualifying edge: 0 rise, 1 fall, 2 both, 3 none |
| pwm_invert | input | 1 | Inverts the PWM pin |
| stall_en | input | 1 | Allows debug halt to freeze the count |
| dbg_halt | input | 1 | Debug halt request |
| cap_in | input | 1 | Synchronized external capture input |
| clr_timeout | input | 1 | Clears the timeout flag |
| clr_event | input | 1 | Clears the event flag |
| count_val | output | 16 | Current counter value |
| capture_val | output | 16 | Last captured count |
| timeout_flag | output | 1 | Sticky timeout flag |
| event_flag | output | 1 | Sticky capture/match flag |
| pwm_out | output | 1 | PWM pin |

## Verification
The embedded properties check the following on every clock:

- a stalled count never moves;
- a finished one-shot stays at zero;
- an idle channel keeps its count;
- an edge in edge-count mode steps the counter by exactly one away from the match;
- a capture copies the previous count;
- prescaler ticks are spaced;
- flags obey set-over-clear.

Only the directed scenarios can show the absolute timing: the clock at which a timeout lands for a given prescale and load, the reload values, and which edge encodings count. They also show the PWM threshold and inversion, and that a load written while running waits for the next reload.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;

    localparam int TMR_CNT_W = 16;
    localparam int TMR_PRE_W = 8;

    typedef enum logic [2:0] {
        MODE_ONESHOT    = 3'd0,
        MODE_PERIODIC   = 3'd1,
        MODE_EDGE_COUNT = 3'd2,
        MODE_EDGE_TIME  = 3'd3,
        MODE_PWM        = 3'd4
    } tmr_mode_e;

    typedef enum logic [1:0] {
        EDGE_RISE = 2'd0,
        EDGE_FALL = 2'd1,
        EDGE_BOTH = 2'd2,
        EDGE_NONE = 2'd3
    } edge_sel_e;

    // Per-mode control bits steering the shared counter core.
    typedef struct packed {
        logic uses_tick;      // counter advances on prescaler ticks
        logic reloads;        // reload from load register instead of reaching zero
        logic raises_timeout; // step to end raises timeout (also the stallable set)
        logic is_oneshot;
        logic is_ecount;
        logic is_etime;
    } mode_dec_t;

    function automatic mode_dec_t decode_mode(input logic [2:0] m);
        mode_dec_t d;
        d = '0;
        case (m)
            MODE_ONESHOT: begin
                d.uses_tick      = 1'b1;
                d.raises_timeout = 1'b1;
                d.is_oneshot     = 1'b1;
            end
            MODE_PERIODIC: begin
                d.uses_tick      = 1'b1;
                d.reloads        = 1'b1;
                d.raises_timeout = 1'b1;
            end
            MODE_EDGE_COUNT: begin
                d.is_ecount = 1'b1;
            end
            MODE_EDGE_TIME: begin
                d.uses_tick = 1'b1;
                d.reloads   = 1'b1;
                d.is_etime  = 1'b1;
            end
            MODE_PWM: begin
                d.uses_tick = 1'b1;
                d.reloads   = 1'b1;
            end
            default: d = '0;
        endcase
        return d;
    endfunction

    function automatic logic edge_qualify(input logic [1:0] sel, input logic cur, input logic prev);
        logic rise;
        logic fall;
        rise = cur & ~prev;
        fall = ~cur & prev;
        case (sel)
            EDGE_RISE: return rise;
            EDGE_FALL: return fall;
            EDGE_BOTH: return rise | fall;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             run,
    input  logic [PRE_W-1:0] limit,
    output logic             tick
);

    logic [PRE_W-1:0] pre_q;

    assign tick = run && (pre_q == limit);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            pre_q <= '0;
        end else if (run) begin
            pre_q <= tick ? '0 : pre_q + 1'b1;
        end
    end

    // R2: a nonzero divide never yields ticks on back-to-back clocks
    p_tick_gap_r2: assert property (@(posedge clk) disable iff (rst)
        (tick && limit != '0) |=> (!tick || limit == '0));

endmodule

// File: rtl/tmr_edge_detect.sv
module tmr_edge_detect
    import tmr16_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       din,
    input  logic [1:0] sel,
    output logic       edge_hit
);

    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= din;
        end
    end

    assign edge_hit = edge_qualify(sel, din, prev_q);

    // R6: no qualifying edge while the input is unchanged from the last sample
    p_edge_needs_change_r6: assert property (@(posedge clk) disable iff (rst)
        (din == prev_q) |-> !edge_hit);

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
    import tmr16_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  mode_dec_t        dec,
    input  logic             tick,
    input  logic             edge_hit,
    input  logic             stalled,
    input  logic             load_we,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] match_val,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] capture,
    output logic             done,
    output logic             timeout_pulse,
    output logic             event_pulse
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] load_q;
    logic [CNT_W-1:0] capture_q;
    logic             done_q;
    logic [CNT_W-1:0] cnt_dec;
    logic             at_end;
    logic             tick_step;
    logic             ecount_step;
    logic             ecount_hit;
    logic             etime_hit;

    assign cnt_dec     = count_q - ONE;
    assign at_end      = (count_q <= ONE);
    assign tick_step   = enable && dec.uses_tick && tick;
    assign ecount_step = enable && dec.is_ecount && edge_hit;
    assign ecount_hit  = ecount_step && (cnt_dec == match_val);
    assign etime_hit   = enable && dec.is_etime && edge_hit;

    assign timeout_pulse = tick_step && dec.raises_timeout && at_end;
    assign event_pulse   = ecount_hit || etime_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q   <= '0;
            load_q    <= '0;
            capture_q <= '0;
            done_q    <= 1'b0;
        end else begin
            if (load_we) begin
                load_q <= load_val;
            end
            if (!enable) begin
                done_q <= 1'b0;
                if (load_we) begin
                    count_q <= load_val;
                end else if (done_q) begin
                    count_q <= load_q;
                end
            end else begin
                if (!dec.is_oneshot) begin
                    done_q <= 1'b0;
                end
                if (tick_step) begin
                    if (at_end) begin
                        count_q <= dec.reloads ? load_q : '0;
                        if (dec.is_oneshot) begin
                            done_q <= 1'b1;
                        end
                    end else begin
                        count_q <= cnt_dec;
                    end
                end else if (ecount_step) begin
                    count_q <= ecount_hit ? load_q : cnt_dec;
                end
                if (etime_hit) begin
                    capture_q <= count_q;
                end
            end
        end
    end

    assign count   = count_q;
    assign capture = capture_q;
    assign done    = done_q;

    // R9: a stalled channel keeps its count
    p_stall_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (enable && stalled) |=> $stable(count_q));

    // R3: a finished one-shot stays at zero while enabled
    p_oneshot_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (enable && dec.is_oneshot && done_q) |=> (count_q == '0));

    // R5: an edge away from the match moves the count by exactly one
    p_ecount_step_r5: assert property (@(posedge clk) disable iff (rst)
        (ecount_step && !ecount_hit) |=> (count_q == $past(count_q) - ONE));

    // R7: a capture takes the count held before the edge clock
    p_capture_prev_r7: assert property (@(posedge clk) disable iff (rst)
        etime_hit |=> (capture_q == $past(count_q)));

    // R10: an idle channel without a load strobe keeps its count
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!enable && !load_we && !done_q) |=> $stable(count_q));

endmodule

// File: rtl/tmr_outputs.sv
module tmr_outputs #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] match_val,
    input  logic             invert,
    input  logic             timeout_pulse,
    input  logic             event_pulse,
    input  logic             clr_timeout,
    input  logic             clr_event,
    output logic             timeout_flag,
    output logic             event_flag,
    output logic             pwm_out
);

    logic to_q;
    logic ev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            to_q <= 1'b0;
            ev_q <= 1'b0;
        end else begin
            if (timeout_pulse) begin
                to_q <= 1'b1;
            end else if (clr_timeout) begin
                to_q <= 1'b0;
            end
            if (event_pulse) begin
                ev_q <= 1'b1;
            end else if (clr_event) begin
                ev_q <= 1'b0;
            end
        end
    end

    assign timeout_flag = to_q;
    assign event_flag   = ev_q;
    assign pwm_out      = (count >= match_val) ^ invert;

    // R11: set wins over clear
    p_timeout_set_r11: assert property (@(posedge clk) disable iff (rst)
        timeout_pulse |=> timeout_flag);
    p_event_set_r11: assert property (@(posedge clk) disable iff (rst)
        event_pulse |=> event_flag);

    // R11: a lone clear removes the flag
    p_timeout_clr_r11: assert property (@(posedge clk) disable iff (rst)
        (clr_timeout && !timeout_pulse) |=> !timeout_flag);
    p_event_clr_r11: assert property (@(posedge clk) disable iff (rst)
        (clr_event && !event_pulse) |=> !event_flag);

endmodule

// File: rtl/mtimer16.sv
module mtimer16
    import tmr16_pkg::*;
#(
    parameter int CNT_W = TMR_CNT_W,
    parameter int PRE_W = TMR_PRE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic [2:0]       mode,
    input  logic [PRE_W-1:0] prescale,
    input  logic [CNT_W-1:0] load_val,
    input  logic             load_we,
    input  logic [CNT_W-1:0] match_val,
    input  logic [1:0]       edge_sel,
    input  logic             pwm_invert,
    input  logic             stall_en,
    input  logic             dbg_halt,
    input  logic             cap_in,
    input  logic             clr_timeout,
    input  logic             clr_event,
    output logic [CNT_W-1:0] count_val,
    output logic [CNT_W-1:0] capture_val,
    output logic             timeout_flag,
    output logic             event_flag,
    output logic             pwm_out
);

    mode_dec_t dec;
    logic      stalled;
    logic      tick;
    logic      edge_hit;
    logic      done;
    logic      timeout_pulse;
    logic      event_pulse;
    logic      pre_run;

    assign dec     = decode_mode(mode);
    assign stalled = stall_en && dbg_halt && dec.raises_timeout;
    assign pre_run = enable && dec.uses_tick && !stalled && !done;

    tmr_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk   (clk),
        .rst   (rst),
        .clear (!enable),
        .run   (pre_run),
        .limit (prescale),
        .tick  (tick)
    );

    tmr_edge_detect u_edge (
        .clk      (clk),
        .rst      (rst),
        .din      (cap_in),
        .sel      (edge_sel),
        .edge_hit (edge_hit)
    );

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk           (clk),
        .rst           (rst),
        .enable        (enable),
        .dec           (dec),
        .tick          (tick),
        .edge_hit      (edge_hit),
        .stalled       (stalled),
        .load_we       (load_we),
        .load_val      (load_val),
        .match_val     (match_val),
        .count         (count_val),
        .capture       (capture_val),
        .done          (done),
        .timeout_pulse (timeout_pulse),
        .event_pulse   (event_pulse)
    );

    tmr_outputs #(.CNT_W(CNT_W)) u_out (
        .clk           (clk),
        .rst           (rst),
        .count         (count_val),
        .match_val     (match_val),
        .invert        (pwm_invert),
        .timeout_pulse (timeout_pulse),
        .event_pulse   (event_pulse),
        .clr_timeout   (clr_timeout),
        .clr_event     (clr_event),
        .timeout_flag  (timeout_flag),
        .event_flag    (event_flag),
        .pwm_out       (pwm_out)
    );

    // R4: timeouts come only from the two plain timer modes
    p_timeout_src_r4: assert property (@(posedge clk) disable iff (rst)
        timeout_pulse |-> (mode == MODE_ONESHOT || mode == MODE_PERIODIC));

endmodule

// File: tb/tb_mtimer16.sv
`timescale 1ns/1ps
module tb_mtimer16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable = 1'b0;
    logic [2:0]  mode = 3'd0;
    logic [7:0]  prescale = 8'd0;
    logic [15:0] load_val = 16'd0;
    logic        load_we = 1'b0;
    logic [15:0] match_val = 16'd0;
    logic [1:0]  edge_sel = 2'd0;
    logic        pwm_invert = 1'b0;
    logic        stall_en = 1'b0;
    logic        dbg_halt = 1'b0;
    logic        cap_in = 1'b0;
    logic        clr_timeout = 1'b0;
    logic        clr_event = 1'b0;
    logic [15:0] count_val;
    logic [15:0] capture_val;
    logic        timeout_flag;
    logic        event_flag;
    logic        pwm_out;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    mtimer16 dut (
        .clk(clk), .rst(rst), .enable(enable), .mode(mode), .prescale(prescale),
        .load_val(load_val), .load_we(load_we), .match_val(match_val),
        .edge_sel(edge_sel), .pwm_invert(pwm_invert), .stall_en(stall_en),
        .dbg_halt(dbg_halt), .cap_in(cap_in), .clr_timeout(clr_timeout),
        .clr_event(clr_event), .count_val(count_val), .capture_val(capture_val),
        .timeout_flag(timeout_flag), .event_flag(event_flag), .pwm_out(pwm_out)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Disabled preload of a mode, then enable at a falling edge.
    task automatic setup(input logic [2:0] m, input logic [7:0] p, input logic [15:0] ld,
                         input logic [15:0] mt, input logic [1:0] es);
        enable = 1'b0; stall_en = 1'b0; dbg_halt = 1'b0; pwm_invert = 1'b0; cap_in = 1'b0;
        mode = m; prescale = p; match_val = mt; edge_sel = es;
        load_val = ld; load_we = 1'b1; clr_timeout = 1'b1; clr_event = 1'b1;
        step(1);
        load_we = 1'b0; clr_timeout = 1'b0; clr_event = 1'b0;
        step(1);
        chk("R10", "preload while disabled", count_val, ld);
        enable = 1'b1;
    endtask

    task automatic pulse_in();
        cap_in = 1'b1; step(1);
        cap_in = 1'b0; step(1);
    endtask

    task automatic t_reset();
        chk("R1", "count", count_val, 0);
        chk("R1", "capture", capture_val, 0);
        chk("R1", "timeout flag", timeout_flag, 0);
        chk("R1", "event flag", event_flag, 0);
    endtask

    task automatic t_oneshot();
        setup(3'd0, 8'd2, 16'd5, 16'd0, 2'd0);
        step(2);
        chk("R2", "no step before prescale+1", count_val, 5);
        step(1);
        chk("R2", "first step", count_val, 4);
        step(11);
        chk("R3", "count before end", count_val, 1);
        chk("R3", "no early timeout", timeout_flag, 0);
        step(1);
        chk("R3", "reaches zero", count_val, 0);
        chk("R3", "timeout flag", timeout_flag, 1);
        step(15);
        chk("R3", "holds at zero", count_val, 0);
        enable = 1'b0;
        step(1);
        chk("R3", "reload on disable", count_val, 5);
    endtask

    task automatic t_periodic();
        setup(3'd1, 8'd0, 16'd4, 16'd0, 2'd0);
        step(3);
        chk("R4", "count before wrap", count_val, 1);
        chk("R4", "flag before wrap", timeout_flag, 0);
        step(1);
        chk("R4", "reloads", count_val, 4);
        chk("R4", "timeout flag", timeout_flag, 1);
        clr_timeout = 1'b1; step(1); clr_timeout = 1'b0;
        chk("R11", "clear pulse", timeout_flag, 0);
        chk("R4", "keeps running", count_val, 3);
        clr_timeout = 1'b1; step(3); clr_timeout = 1'b0;
        chk("R11", "set wins over clear", timeout_flag, 1);
        chk("R4", "second reload", count_val, 4);
        load_val = 16'd50; load_we = 1'b1; step(1); load_we = 1'b0;
        chk("R10", "load ignored by running counter", count_val, 3);
        step(3);
        chk("R10", "new load used at reload", count_val, 50);
    endtask

    task automatic t_stall();
        setup(3'd1, 8'd0, 16'd100, 16'd0, 2'd0);
        step(10);
        chk("R9", "running", count_val, 90);
        stall_en = 1'b1; dbg_halt = 1'b1; step(20);
        chk("R9", "frozen by halt", count_val, 90);
        dbg_halt = 1'b0; step(5);
        chk("R9", "resumes", count_val, 85);
        stall_en = 1'b0; dbg_halt = 1'b1; step(5);
        chk("R9", "halt ignored without stall enable", count_val, 80);
        dbg_halt = 1'b0;
    endtask

    task automatic t_ecount();
        setup(3'd2, 8'd0, 16'd10, 16'd7, 2'd0);
        step(3);
        chk("R5", "no tick counting", count_val, 10);
        pulse_in();
        chk("R5", "one rise", count_val, 9);
        pulse_in();
        chk("R5", "two rises", count_val, 8);
        chk("R5", "no event yet", event_flag, 0);
        pulse_in();
        chk("R5", "reload at match", count_val, 10);
        chk("R5", "event flag", event_flag, 1);
        setup(3'd2, 8'd0, 16'd10, 16'd0, 2'd1);
        cap_in = 1'b1; step(1);
        chk("R6", "rise ignored under falling select", count_val, 10);
        cap_in = 1'b0; step(1);
        chk("R6", "fall counted", count_val, 9);
        edge_sel = 2'd2;
        pulse_in();
        chk("R6", "both edges counted", count_val, 7);
        edge_sel = 2'd3;
        pulse_in();
        chk("R6", "no edges counted", count_val, 7);
    endtask

    task automatic t_etime();
        logic [15:0] seen;
        setup(3'd3, 8'd0, 16'd1000, 16'd0, 2'd0);
        step(7);
        chk("R7", "free-running count", count_val, 993);
        seen = count_val;
        cap_in = 1'b1; step(1);
        chk("R7", "captured value", capture_val, seen);
        chk("R7", "event flag", event_flag, 1);
        chk("R7", "keeps counting", count_val, 992);
        cap_in = 1'b0; step(1);
    endtask

    task automatic t_pwm();
        setup(3'd4, 8'd0, 16'd8, 16'd3, 2'd0);
        step(4);
        chk("R8", "count 4", count_val, 4);
        chk("R8", "high above match", pwm_out, 1);
        step(1);
        chk("R8", "high at match", pwm_out, 1);
        step(1);
        chk("R8", "low below match", pwm_out, 0);
        step(2);
        chk("R8", "reload", count_val, 8);
        chk("R8", "no timeout in PWM", timeout_flag, 0);
        pwm_invert = 1'b1; step(1);
        chk("R8", "inverted", pwm_out, 0);
        stall_en = 1'b1; dbg_halt = 1'b1; step(2);
        chk("R9", "PWM not stalled", count_val, 5);
        stall_en = 1'b0; dbg_halt = 1'b0;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        step(3);
        rst = 1'b0;
        step(1);
        t_reset();
        t_oneshot();
        t_periodic();
        t_stall();
        t_ecount();
        t_etime();
        t_pwm();
        summary();
        $finish;
    end

endmodule